// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block sits between the input comparators of a half-bridge gate driver and its gate-control stage. It takes the digitised flags that describe where a three-level PWM line currently sits. It turns them into one registered command: drive the high-side switch, drive the low-side switch, or turn both off. It runs from a fast sampling clock. Every flag is resynchronised before it is used.

Two signalling conventions are supported, chosen by a mode input. In fast mode, a level above the over-range threshold forces both switches off at once. Switching resumes as soon as the level returns to the normal range. In generic mode, the line must rest inside a mid-level window for a hold-off time before both switches are turned off. A shorter visit to the window leaves the current command in place. After reset the block keeps both switches off until it has decoded one disable condition and seen the line leave it. It flags every departure from the off state with a one-cycle pulse.

Top module: `trilevel_cmd_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmd_o` is 2'b00, `off_o` is 1 and `resume_o` is 0.
- R2: After reset, `cmd_o` stays 2'b00 whatever the PWM level, until a disable condition (R4 or R6) has been decoded and then left.
- R3: Command encoding is 2'b00 off, 2'b01 low side, 2'b10 high side; 2'b11 never appears. Outside a disable condition or a pending window, `lvl_high_i`=1 gives 2'b10 and 0 gives 2'b01, three rising edges after the input changes.
- R4: With `mode_generic_i`=0, `lvl_over_i`=1 makes `cmd_o` 2'b00 at the third rising edge, with no hold-off, and `lvl_mid_i` has no effect.
- R5: In fast mode, when `lvl_over_i` returns to 0, `cmd_o` follows `lvl_high_i` again at the third rising edge.
- R6: With `mode_generic_i`=1, `lvl_mid_i` held for HOLD_CYC consecutive synchronised cycles gives `cmd_o`=2'b00. HOLD_CYC is the ceiling of HOLDOFF_PS/CLK_PERIOD_PS, and at least 1. For input held from cycle n, the command is off after edge n+HOLD_CYC+2. In this mode `lvl_over_i` has no effect.
- R7: In generic mode, a window visit shorter than HOLD_CYC keeps the previous command for its duration and never disables. The hold-off count restarts from zero each time the line leaves the window.
- R8: `resume_o` is 1 for exactly one cycle, the first cycle in which `cmd_o` has left 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_generic_i | input | 1 | 0 = fast over-level disable, 1 = windowed hold-off disable (asynchronous) |
| lvl_high_i | input | 1 | Line above the logic-high threshold (asynchronous) |
| lvl_over_i | input | 1 | Line above the over-range disable threshold (asynchronous) |
| lvl_mid_i | input | 1 | Line inside the mid-level window (asynchronous) |
| cmd_o | output | 2 | Decoded command: 00 off, 01 low side, 10 high side |
| off_o | output | 1 | 1 while the command is off |
| resume_o | output | 1 | One-cycle pulse on leaving the off command |

## Verification
The bench builds the decoder with CLK_PERIOD_PS=5000 and HOLDOFF_PS=20000, which gives a four-cycle hold-off. With that setting, window visits of three cycles (no disable) and four or more cycles (disable) both fit in a short run. So do two three-cycle visits separated by a one-cycle gap, which would disable if the count did not restart. The synchroniser keeps its default depth of two, so every expected output change falls on a fixed edge counted from the input change.

// File: rtl/tlcd_pkg.sv
package tlcd_pkg;

    typedef enum logic [1:0] {
        CMD_OFF  = 2'b00,
        CMD_LOW  = 2'b01,
        CMD_HIGH = 2'b10
    } drive_cmd_e;

    typedef struct packed {
        drive_cmd_e cmd;
        logic       lock;
        logic       resume;
    } dec_state_s;

    localparam int FLAG_MODE = 0;
    localparam int FLAG_HIGH = 1;
    localparam int FLAG_OVER = 2;
    localparam int FLAG_MID  = 3;
    localparam int FLAG_NUM  = 4;

endpackage

// File: rtl/tlcd_sync.sv
module tlcd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int DEPTH = (STAGES < 1) ? 1 : STAGES;

    logic [DEPTH-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[DEPTH-1];
endmodule

// File: rtl/tlcd_holdoff.sv
module tlcd_holdoff #(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic hit_o
);
    localparam int LIMIT = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!arm_i)           cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = arm_i && (cnt_q == LAST);

    // R6: the count saturates at its terminal value
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7: leaving the window restarts the count
    assert_cnt_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (cnt_q == '0));
endmodule

// File: rtl/trilevel_cmd_decoder.sv
module trilevel_cmd_decoder
    import tlcd_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int HOLDOFF_PS    = 80000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_generic_i,
    input  logic       lvl_high_i,
    input  logic       lvl_over_i,
    input  logic       lvl_mid_i,
    output logic [1:0] cmd_o,
    output logic       off_o,
    output logic       resume_o
);
    localparam int HOLD_RAW = (HOLDOFF_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

    logic [FLAG_NUM-1:0] flags_async, flags_s;
    logic gen_s, hi_s, over_s, mid_s;
    logic hold_hit;
    logic over_dis, mid_dis, dis_cond, mid_wait;
    drive_cmd_e lvl_cmd;
    dec_state_s st_d, st_q;

    always_comb begin
        flags_async            = '0;
        flags_async[FLAG_MODE] = mode_generic_i;
        flags_async[FLAG_HIGH] = lvl_high_i;
        flags_async[FLAG_OVER] = lvl_over_i;
        flags_async[FLAG_MID]  = lvl_mid_i;
    end

    tlcd_sync #(
        .WIDTH  (FLAG_NUM),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flags_async),
        .sync_o  (flags_s)
    );

    assign gen_s  = flags_s[FLAG_MODE];
    assign hi_s   = flags_s[FLAG_HIGH];
    assign over_s = flags_s[FLAG_OVER];
    assign mid_s  = flags_s[FLAG_MID];

    tlcd_holdoff #(
        .HOLD_CYC (HOLD_CYC)
    ) u_holdoff (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_i (gen_s && mid_s),
        .hit_o (hold_hit)
    );

    always_comb begin
        over_dis = !gen_s && over_s;
        mid_dis  = gen_s && hold_hit;
        dis_cond = over_dis || mid_dis;
        mid_wait = gen_s && mid_s && !hold_hit;
        lvl_cmd  = hi_s ? CMD_HIGH : CMD_LOW;

        st_d = st_q;
        if (dis_cond) begin
            st_d.cmd  = CMD_OFF;
            st_d.lock = 1'b0;
        end else if (st_q.lock) begin
            st_d.cmd  = CMD_OFF;
        end else if (mid_wait) begin
            st_d.cmd  = st_q.cmd;
        end else begin
            st_d.cmd  = lvl_cmd;
        end
        st_d.resume = (st_q.cmd == CMD_OFF) && (st_d.cmd != CMD_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmd    <= CMD_OFF;
            st_q.lock   <= 1'b1;
            st_q.resume <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o    = st_q.cmd;
    assign off_o    = (st_q.cmd == CMD_OFF);
    assign resume_o = st_q.resume;

    // R3: the unused code never reaches the output
    assert_cmd_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o != 2'b11);

    // R2: the start-up lock keeps both switches off
    assert_lock_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> (cmd_o == 2'b00));

    // R4: a synchronised over-level in fast mode turns both off next cycle
    assert_fast_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_s && over_s) |=> (cmd_o == 2'b00));

    // R6: an expired hold-off in generic mode turns both off next cycle
    assert_window_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_s && hold_hit) |=> (cmd_o == 2'b00));

    // R8: the resume pulse marks the first cycle after the off command
    assert_resume_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> ((cmd_o != 2'b00) && ($past(cmd_o) == 2'b00)));
endmodule

// File: tb/trilevel_cmd_decoder_bench.sv
module trilevel_cmd_decoder_bench;

    typedef struct {
        int         due;
        logic [1:0] cmd;
        logic       chk_res;
        logic       res;
        string      tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_generic_i = 1'b0;
    logic lvl_high_i = 1'b0;
    logic lvl_over_i = 1'b0;
    logic lvl_mid_i = 1'b0;
    logic [1:0] cmd_o;
    logic off_o;
    logic resume_o;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    exp_item_t sb[$];
    exp_item_t cur;

    always #2.5 clk = ~clk;

    trilevel_cmd_decoder #(
        .CLK_PERIOD_PS (5000),
        .HOLDOFF_PS    (20000),
        .SYNC_STAGES   (2)
    ) u_trilevel_cmd_decoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_generic_i (mode_generic_i),
        .lvl_high_i     (lvl_high_i),
        .lvl_over_i     (lvl_over_i),
        .lvl_mid_i      (lvl_mid_i),
        .cmd_o          (cmd_o),
        .off_o          (off_o),
        .resume_o       (resume_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops every expectation that falls due in this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            cur = sb.pop_front();
            n_cmp++;
            if (cur.due != cyc) begin
                n_bad++;
                $display("FAIL %s: expectation missed at cycle %0d (due %0d)", cur.tag, cyc, cur.due);
            end else if (cmd_o !== cur.cmd || off_o !== (cur.cmd == 2'b00) ||
                         (cur.chk_res && resume_o !== cur.res)) begin
                n_bad++;
                $display("FAIL %s: cycle %0d cmd=%b off=%b resume=%b, expected cmd=%b off=%b resume=%b",
                         cur.tag, cyc, cmd_o, off_o, resume_o, cur.cmd, (cur.cmd == 2'b00), cur.res);
            end
        end
    end

    task automatic expect_at(input int d, input logic [1:0] c, input logic chk,
                             input logic r, input string tag);
        exp_item_t it;
        int pos;
        it.due = cyc + d;
        it.cmd = c;
        it.chk_res = chk;
        it.res = r;
        it.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].due > it.due) begin
                pos = i;
                break;
            end
        end
        sb.insert(pos, it);
    endtask

    task automatic drive(input logic g, input logic h, input logic o, input logic m);
        mode_generic_i = g;
        lvl_high_i = h;
        lvl_over_i = o;
        lvl_mid_i = m;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        tick(1);
        expect_at(1, 2'b00, 1'b1, 1'b0, "R1 during reset");
        tick(2);
        rst_n = 1'b1;
        expect_at(1, 2'b00, 1'b1, 1'b0, "R1 first cycle after reset");
        expect_at(3, 2'b00, 1'b1, 1'b0, "R2 lock holds with high level");
        expect_at(6, 2'b00, 1'b1, 1'b0, "R2 lock still holds");
        settle();

        // fast mode over-level disable then resume
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        expect_at(3, 2'b00, 1'b1, 1'b0, "R4 over-level off");
        settle();
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        expect_at(2, 2'b00, 1'b1, 1'b0, "R5 not yet resumed");
        expect_at(3, 2'b10, 1'b1, 1'b1, "R5 R8 resume high with pulse");
        expect_at(4, 2'b10, 1'b1, 1'b0, "R8 pulse lasts one cycle");
        settle();

        drive(1'b0, 1'b0, 1'b0, 1'b0);
        expect_at(2, 2'b10, 1'b1, 1'b0, "R3 latency, still high");
        expect_at(3, 2'b01, 1'b1, 1'b0, "R3 low side");
        settle();

        drive(1'b0, 1'b0, 1'b0, 1'b1);
        expect_at(6, 2'b01, 1'b1, 1'b0, "R4 window ignored in fast mode");
        settle();
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        expect_at(3, 2'b00, 1'b1, 1'b0, "R4 over-level off from low");
        settle();
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        expect_at(3, 2'b01, 1'b1, 1'b1, "R5 R8 resume low with pulse");
        settle();

        // generic mode
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        tick(4);
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        expect_at(3, 2'b10, 1'b1, 1'b0, "R6 over-level ignored in generic mode");
        expect_at(6, 2'b10, 1'b1, 1'b0, "R6 over-level still ignored");
        settle();

        drive(1'b1, 1'b0, 1'b0, 1'b1);
        expect_at(3, 2'b10, 1'b1, 1'b0, "R7 short window holds command");
        expect_at(4, 2'b10, 1'b1, 1'b0, "R7 short window holds command");
        expect_at(5, 2'b10, 1'b1, 1'b0, "R7 short window no disable");
        tick(3);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        expect_at(3, 2'b01, 1'b1, 1'b0, "R7 level applies after window");
        settle();

        drive(1'b1, 1'b0, 1'b0, 1'b1);
        expect_at(4, 2'b01, 1'b1, 1'b0, "R7 first partial window");
        expect_at(6, 2'b01, 1'b1, 1'b0, "R7 gap");
        expect_at(8, 2'b01, 1'b1, 1'b0, "R7 count restarted");
        expect_at(10, 2'b01, 1'b1, 1'b0, "R7 count restarted");
        expect_at(12, 2'b01, 1'b1, 1'b0, "R7 no disable after split windows");
        tick(3);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        tick(1);
        drive(1'b1, 1'b0, 1'b0, 1'b1);
        tick(3);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        settle();

        drive(1'b1, 1'b0, 1'b0, 1'b1);
        expect_at(5, 2'b01, 1'b1, 1'b0, "R6 one cycle before hold-off expires");
        expect_at(6, 2'b00, 1'b1, 1'b0, "R6 hold-off expired, off");
        tick(6);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        expect_at(2, 2'b00, 1'b1, 1'b0, "R6 off until window left");
        expect_at(3, 2'b10, 1'b1, 1'b1, "R8 resume from window disable");
        expect_at(4, 2'b10, 1'b1, 1'b0, "R8 pulse ends");
        settle();

        // reset in mid-run, then start-up lock in generic mode
        rst_n = 1'b0;
        expect_at(1, 2'b00, 1'b1, 1'b0, "R1 reset from high");
        tick(2);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        expect_at(5, 2'b00, 1'b1, 1'b0, "R2 lock after reset");
        settle();
        drive(1'b1, 1'b0, 1'b0, 1'b1);
        expect_at(6, 2'b00, 1'b1, 1'b0, "R2 window decoded while locked");
        tick(6);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        expect_at(3, 2'b01, 1'b1, 1'b1, "R2 lock released on window exit");
        settle();

        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 20000) @(negedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule